// File: doc/BRIEF.md
# Key-Locked Masked Register Bank

This block holds a bank of 16-bit configuration registers behind a plain synchronous access port. A host presents an address, a strobe and data, and a single write may carry up to `BURST` consecutive registers at once. Every register has two fixed bit masks chosen at elaboration. The write mask limits which bits a write may change, and the read mask limits which bits a read may show.

A few registers are critical to safety and sit in two protected address windows. Writes into those windows go through only while a dedicated key register holds the unlock value 0x0013. Any other value in the key register, including the 0x0000 used to lock, leaves the windows closed. The key register itself is always writable. Refused accesses change nothing and raise the error flag for one cycle.

The mask tables, reset values, key register address and window bounds are parameters. The serial link that carries the accesses sits outside the block.

Top module: `regbank_keylock`

## Requirements
- R1: Reset sets every register to its reset value, leaves the bank locked, and drives `acc_rdata` and `acc_err` to 0. With the defaults, register 0 resets to 0xA5C3, register 1 to 0x0042, registers with address mod 4 = 3 to 0xAB00, and all others to 0.
- R2: Inputs are sampled on the rising clock edge, and `acc_rdata`/`acc_err` are valid in the following cycle. `acc_rdata` holds its value on cycles without a read.
- R3: Read data equals the stored value ANDed with the register's read mask. With the defaults, registers with address mod 4 = 2 mask to 0x7FFF and all others to 0xFFFF.
- R4: An accepted write changes only the bits set in the register's write mask, and all other bits keep their value. With the defaults, registers with address mod 4 = 3 have write mask 0x00FF, registers 0 and 1 have 0x0000, and all others have 0xFFFF.
- R5: A write that touches a register whose write mask is zero is refused with an error, and no register changes.
- R6: An access to an address at or above `NUM_REGS` (32 by default) is refused with an error. A refused read returns 0.
- R7: The key register (address 2 by default) accepts writes in any lock state. The bank is unlocked exactly while the key register holds 0x0013, and any other value locks it.
- R8: While locked, writes to addresses 8 to 11 and 20 to 22 (the defaults) are refused with an error.
- R9: `acc_cnt` is the beat count minus one. Beat k is taken from `acc_wdata[16k +: 16]` and goes to `acc_addr + k`. If any beat would be refused, the whole write is refused and no register changes.
- R10: A read and a write in the same cycle are allowed. The read returns the contents from before the write, and the error flag reports a refusal from either access.
- R11: `acc_err` is high only in the cycle after a refused access, and low after a cycle that has no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_addr | input | ADDR_W | Register address (first beat of a write) |
| acc_cnt | input | CNT_W | Number of write beats minus one |
| acc_wdata | input | BURST*16 | Write data, beat k in bits 16k+15:16k |
| acc_we | input | 1 | Write strobe |
| acc_re | input | 1 | Read strobe |
| acc_rdata | output | 16 | Masked read data, registered |
| acc_err | output | 1 | Refusal flag, registered |

## Verification
The bench uses the default parameters: 32 registers, a 6-bit address, 4-beat writes, the key register at address 2, and the protected windows at 8 to 11 and 20 to 22. The 6-bit address can reach past the last register, so out-of-range reads and writes can be exercised. A 4-beat write can start inside the bank and run past its end, or start outside a protected window and run into it. The default masks include read-only registers, a narrowed read mask and a narrowed write mask, with nonzero reset values in the bits that cannot be written. This shows that those bits are preserved.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DW       = 16;
    localparam int DEF_REGS = 32;

    typedef struct packed {
        logic [DW-1:0] rdata;
        logic          err;
    } port_state_t;

    function automatic logic [DEF_REGS*DW-1:0] def_wr_mask();
        logic [DEF_REGS*DW-1:0] v;
        v = '0;
        for (int i = 0; i < DEF_REGS; i++) begin
            if (i < 2)
                v[i*DW +: DW] = 16'h0000;
            else if (i % 4 == 3)
                v[i*DW +: DW] = 16'h00FF;
            else
                v[i*DW +: DW] = 16'hFFFF;
        end
        return v;
    endfunction

    function automatic logic [DEF_REGS*DW-1:0] def_rd_mask();
        logic [DEF_REGS*DW-1:0] v;
        v = '0;
        for (int i = 0; i < DEF_REGS; i++)
            v[i*DW +: DW] = (i % 4 == 2) ? 16'h7FFF : 16'hFFFF;
        return v;
    endfunction

    function automatic logic [DEF_REGS*DW-1:0] def_reset();
        logic [DEF_REGS*DW-1:0] v;
        v = '0;
        for (int i = 0; i < DEF_REGS; i++) begin
            if (i == 0)
                v[i*DW +: DW] = 16'hA5C3;
            else if (i == 1)
                v[i*DW +: DW] = 16'h0042;
            else if (i % 4 == 3)
                v[i*DW +: DW] = 16'hAB00;
            else
                v[i*DW +: DW] = 16'h0000;
        end
        return v;
    endfunction

endpackage

// File: rtl/regbank_guard.sv
// Decides, for a whole write, whether every beat may land.
module regbank_guard
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int ADDR_W   = 6,
    parameter int BURST    = 4,
    parameter int CNT_W    = 2,
    parameter int SEC_ADDR = 2,
    parameter int PA_LO    = 8,
    parameter int PA_HI    = 11,
    parameter int PB_LO    = 20,
    parameter int PB_HI    = 22,
    parameter logic [NUM_REGS*DW-1:0] WR_MASK = def_wr_mask()
) (
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              unlocked,
    output logic              wr_ok,
    output logic              wr_err
);

    logic [BURST-1:0] beat_bad;

    for (genvar b = 0; b < BURST; b++) begin : g_beat
        logic          active;
        logic          oob;
        logic          prot;
        logic [DW-1:0] wm;
        int            a_b;

        always_comb begin
            a_b    = int'(addr) + b;
            active = (b <= int'(cnt));
            oob    = (a_b >= NUM_REGS);
            wm     = '0;
            for (int r = 0; r < NUM_REGS; r++)
                if (a_b == r)
                    wm = WR_MASK[r*DW +: DW];
            prot = (a_b != SEC_ADDR) &&
                   (((a_b >= PA_LO) && (a_b <= PA_HI)) ||
                    ((a_b >= PB_LO) && (a_b <= PB_HI)));
            beat_bad[b] = active && (oob || (wm == '0) || (!unlocked && prot));
        end
    end

    assign wr_ok  = wr_req && (beat_bad == '0);
    assign wr_err = wr_req && (beat_bad != '0);

endmodule

// File: rtl/regbank_store.sv
// Register storage with per-bit write masking; up to BURST beats per write.
module regbank_store
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int ADDR_W   = 6,
    parameter int BURST    = 4,
    parameter int CNT_W    = 2,
    parameter logic [NUM_REGS*DW-1:0] WR_MASK = def_wr_mask(),
    parameter logic [NUM_REGS*DW-1:0] RST_VAL = def_reset()
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [BURST*DW-1:0]    wdata,
    output logic [NUM_REGS*DW-1:0] regs_flat
);

    localparam logic [NUM_REGS-1:0][DW-1:0] WM      = WR_MASK;
    localparam logic [NUM_REGS-1:0][DW-1:0] RST_ARR = RST_VAL;

    logic [NUM_REGS-1:0][DW-1:0] regs_d, regs_q;
    logic [BURST-1:0][DW-1:0]    beats;

    assign beats = wdata;

    always_comb begin
        regs_d = regs_q;
        if (commit) begin
            for (int b = 0; b < BURST; b++) begin
                if (b <= int'(cnt)) begin
                    for (int r = 0; r < NUM_REGS; r++) begin
                        if (int'(addr) + b == r)
                            regs_d[r] = (regs_q[r] & ~WM[r]) | (beats[b] & WM[r]);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= RST_ARR;
        else
            regs_q <= regs_d;
    end

    assign regs_flat = regs_q;

endmodule

// File: rtl/regbank_rdport.sv
// Read selection with per-register readable-bit mask.
module regbank_rdport
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int ADDR_W   = 6,
    parameter logic [NUM_REGS*DW-1:0] RD_MASK = def_rd_mask()
) (
    input  logic [ADDR_W-1:0]      addr,
    input  logic [NUM_REGS*DW-1:0] regs_flat,
    output logic [DW-1:0]          rd_val,
    output logic                   rd_oob
);

    always_comb begin
        rd_val = '0;
        rd_oob = (int'(addr) >= NUM_REGS);
        for (int r = 0; r < NUM_REGS; r++)
            if (int'(addr) == r)
                rd_val = regs_flat[r*DW +: DW] & RD_MASK[r*DW +: DW];
    end

endmodule

// File: rtl/regbank_keylock.sv
module regbank_keylock
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int ADDR_W   = 6,
    parameter int BURST    = 4,
    parameter int SEC_ADDR = 2,
    parameter logic [DW-1:0] UNLOCK_KEY = 16'h0013,
    parameter int PA_LO    = 8,
    parameter int PA_HI    = 11,
    parameter int PB_LO    = 20,
    parameter int PB_HI    = 22,
    parameter logic [NUM_REGS*DW-1:0] WR_MASK = def_wr_mask(),
    parameter logic [NUM_REGS*DW-1:0] RD_MASK = def_rd_mask(),
    parameter logic [NUM_REGS*DW-1:0] RST_VAL = def_reset(),
    localparam int CNT_W = $clog2(BURST)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [CNT_W-1:0]    acc_cnt,
    input  logic [BURST*DW-1:0] acc_wdata,
    input  logic                acc_we,
    input  logic                acc_re,
    output logic [DW-1:0]       acc_rdata,
    output logic                acc_err
);

    logic [NUM_REGS*DW-1:0] regs_flat;
    logic [DW-1:0]          key_val;
    logic                   unlocked;
    logic                   wr_ok, wr_err;
    logic [DW-1:0]          rd_val;
    logic                   rd_oob;
    port_state_t            state_d, state_q;

    assign key_val  = regs_flat[SEC_ADDR*DW +: DW];
    assign unlocked = (key_val == UNLOCK_KEY);

    regbank_guard #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BURST(BURST), .CNT_W(CNT_W),
        .SEC_ADDR(SEC_ADDR), .PA_LO(PA_LO), .PA_HI(PA_HI),
        .PB_LO(PB_LO), .PB_HI(PB_HI), .WR_MASK(WR_MASK)
    ) guard_i (
        .wr_req  (acc_we),
        .addr    (acc_addr),
        .cnt     (acc_cnt),
        .unlocked(unlocked),
        .wr_ok   (wr_ok),
        .wr_err  (wr_err)
    );

    regbank_store #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .BURST(BURST), .CNT_W(CNT_W),
        .WR_MASK(WR_MASK), .RST_VAL(RST_VAL)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (wr_ok),
        .addr     (acc_addr),
        .cnt      (acc_cnt),
        .wdata    (acc_wdata),
        .regs_flat(regs_flat)
    );

    regbank_rdport #(
        .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .RD_MASK(RD_MASK)
    ) rdport_i (
        .addr     (acc_addr),
        .regs_flat(regs_flat),
        .rd_val   (rd_val),
        .rd_oob   (rd_oob)
    );

    // Read sees the pre-write contents because storage updates on the same edge.
    always_comb begin
        state_d     = state_q;
        state_d.err = wr_err || (acc_re && rd_oob);
        if (acc_re)
            state_d.rdata = rd_oob ? '0 : rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign acc_rdata = state_q.rdata;
    assign acc_err   = state_q.err;

endmodule

// File: rtl/regbank_keylock_chk.sv
module regbank_keylock_chk
    import regbank_pkg::*;
#(
    parameter int NUM_REGS = DEF_REGS,
    parameter int ADDR_W   = 6,
    parameter int CNT_W    = 2,
    parameter int SEC_ADDR = 2,
    parameter int PA_LO    = 8,
    parameter int PA_HI    = 11,
    parameter logic [NUM_REGS*DW-1:0] WR_MASK = def_wr_mask(),
    parameter logic [NUM_REGS*DW-1:0] RD_MASK = def_rd_mask()
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      acc_addr,
    input logic [CNT_W-1:0]       acc_cnt,
    input logic                   acc_we,
    input logic                   acc_re,
    input logic [DW-1:0]          acc_rdata,
    input logic                   acc_err,
    input logic                   wr_ok,
    input logic                   unlocked,
    input logic [NUM_REGS*DW-1:0] regs_flat
);

    logic [DW-1:0] cur_rm, prev_rm;

    always_comb begin
        cur_rm = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (int'(acc_addr) == r)
                cur_rm = RD_MASK[r*DW +: DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_rm <= '0;
        else        prev_rm <= cur_rm;
    end

    AST_REFUSED_WRITE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !wr_ok) |=> $stable(regs_flat)); // R5

    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_we && !acc_re) |=> !acc_err); // R11

    AST_RD_OOB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_re && int'(acc_addr) >= NUM_REGS) |=> (acc_err && acc_rdata == '0)); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_re |=> $stable(acc_rdata)); // R2

    AST_KEY_ALWAYS_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && acc_cnt == '0 && int'(acc_addr) == SEC_ADDR) |=> !acc_err); // R7

    AST_LOCKED_WINDOW_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && !unlocked && int'(acc_addr) >= PA_LO && int'(acc_addr) <= PA_HI)
        |=> acc_err); // R8

    AST_RD_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        acc_re |=> ((acc_rdata & ~prev_rm) == '0)); // R3

    AST_WR_KEEPS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |=> (((regs_flat ^ $past(regs_flat)) & ~WR_MASK) == '0)); // R4

endmodule

bind regbank_keylock regbank_keylock_chk #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SEC_ADDR(SEC_ADDR),
    .PA_LO(PA_LO), .PA_HI(PA_HI), .WR_MASK(WR_MASK), .RD_MASK(RD_MASK)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_addr (acc_addr),
    .acc_cnt  (acc_cnt),
    .acc_we   (acc_we),
    .acc_re   (acc_re),
    .acc_rdata(acc_rdata),
    .acc_err  (acc_err),
    .wr_ok    (wr_ok),
    .unlocked (unlocked),
    .regs_flat(regs_flat)
);

// File: tb/regbank_keylock_tb_top.sv
module regbank_keylock_tb_top;

    typedef struct packed {
        logic        we;
        logic        re;
        logic [5:0]  addr;
        logic [1:0]  cnt;
        logic [63:0] wd;
        logic        xerr;
        logic        chk;
        logic [15:0] xrd;
        logic [7:0]  req;
    } vec_t;

    function automatic vec_t wr(int a, int c, logic [63:0] d, logic e, int r);
        return '{1'b1, 1'b0, 6'(a), 2'(c), d, e, 1'b0, 16'h0, 8'(r)};
    endfunction
    function automatic vec_t rd(int a, logic [15:0] x, logic e, int r);
        return '{1'b0, 1'b1, 6'(a), 2'd0, 64'h0, e, 1'b1, x, 8'(r)};
    endfunction
    function automatic vec_t rw(int a, logic [15:0] d, logic [15:0] x, logic e, int r);
        return '{1'b1, 1'b1, 6'(a), 2'd0, {48'h0, d}, e, 1'b1, x, 8'(r)};
    endfunction
    function automatic vec_t idle(logic [15:0] x, int r);
        return '{1'b0, 1'b0, 6'd0, 2'd0, 64'h0, 1'b0, 1'b1, x, 8'(r)};
    endfunction

    localparam int NV = 58;
    localparam vec_t TBL [NV] = '{
        rd(0, 16'hA5C3, 1'b0, 1),                // R1 reset value
        rd(1, 16'h0042, 1'b0, 1),                // R1
        rd(3, 16'hAB00, 1'b0, 1),                // R1
        idle(16'hAB00, 2),                       // R2 hold
        wr(5, 0, 64'hFFFF, 1'b0, 4),             // R4
        rd(5, 16'hFFFF, 1'b0, 4),
        wr(6, 0, 64'hFFFF, 1'b0, 3),             // R3
        rd(6, 16'h7FFF, 1'b0, 3),
        wr(3, 0, 64'h1234, 1'b0, 4),             // R4 partial mask
        rd(3, 16'hAB34, 1'b0, 4),
        wr(0, 0, 64'h1111, 1'b1, 5),             // R5 read-only
        rd(0, 16'hA5C3, 1'b0, 5),
        wr(1, 0, 64'hFFFF, 1'b1, 5),
        rd(1, 16'h0042, 1'b0, 5),
        wr(8, 0, 64'hBEEF, 1'b1, 8),             // R8 locked window A
        rd(8, 16'h0000, 1'b0, 8),
        wr(21, 0, 64'h0001, 1'b1, 8),            // R8 locked window B
        rd(21, 16'h0000, 1'b0, 8),
        wr(2, 0, 64'h0013, 1'b0, 7),             // R7 unlock
        rd(2, 16'h0013, 1'b0, 7),
        wr(8, 0, 64'hBEEF, 1'b0, 7),
        rd(8, 16'hBEEF, 1'b0, 7),
        wr(11, 0, 64'hFFFF, 1'b0, 4),
        rd(11, 16'hABFF, 1'b0, 4),
        wr(22, 0, 64'h5555, 1'b0, 7),
        rd(22, 16'h5555, 1'b0, 7),
        wr(2, 0, 64'h0014, 1'b0, 7),             // R7 wrong key locks
        rd(2, 16'h0014, 1'b0, 7),
        wr(9, 0, 64'h0001, 1'b1, 7),
        rd(9, 16'h0000, 1'b0, 7),
        wr(2, 0, 64'h0013, 1'b0, 7),
        wr(2, 0, 64'h0000, 1'b0, 7),             // R7 relock
        wr(20, 0, 64'h0007, 1'b1, 8),
        rd(20, 16'h0000, 1'b0, 8),
        rd(40, 16'h0000, 1'b1, 6),               // R6 read out of range
        idle(16'h0000, 11),                      // R11 error drops
        rd(31, 16'hAB00, 1'b0, 6),
        wr(30, 1, 64'h0000_0000_2222_1111, 1'b0, 9),  // R9
        rd(30, 16'h1111, 1'b0, 9),
        rd(31, 16'hAB22, 1'b0, 9),
        wr(30, 2, 64'h0000_9999_9999_9999, 1'b1, 6),  // R6 burst past end
        rd(30, 16'h1111, 1'b0, 9),
        wr(4, 3, 64'h0707_0606_0505_0404, 1'b0, 9),
        rd(4, 16'h0404, 1'b0, 9),
        rd(5, 16'h0505, 1'b0, 9),
        rd(6, 16'h0606, 1'b0, 9),
        rd(7, 16'hAB07, 1'b0, 9),
        wr(6, 3, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 9),   // R9 into locked window
        rd(6, 16'h0606, 1'b0, 9),
        rd(7, 16'hAB07, 1'b0, 9),
        wr(0, 1, 64'h0000_0000_3333_3333, 1'b1, 9),
        rd(1, 16'h0042, 1'b0, 9),
        rw(5, 16'hAAAA, 16'h0505, 1'b0, 10),     // R10 old data
        rd(5, 16'hAAAA, 1'b0, 10),
        idle(16'hAAAA, 2),
        rw(0, 16'h1111, 16'hA5C3, 1'b1, 10),     // R10 write refused
        wr(45, 0, 64'h0001, 1'b1, 6),            // R6 write out of range
        idle(16'hA5C3, 11)                       // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  acc_addr = '0;
    logic [1:0]  acc_cnt = '0;
    logic [63:0] acc_wdata = '0;
    logic        acc_we = 1'b0;
    logic        acc_re = 1'b0;
    logic [15:0] acc_rdata;
    logic        acc_err;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    regbank_keylock dut_i (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_cnt(acc_cnt),
        .acc_wdata(acc_wdata), .acc_we(acc_we), .acc_re(acc_re),
        .acc_rdata(acc_rdata), .acc_err(acc_err)
    );

    task automatic check(logic ok, int req, logic [15:0] act, logic [15:0] exp, string what);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        acc_we = v.we; acc_re = v.re; acc_addr = v.addr;
        acc_cnt = v.cnt; acc_wdata = v.wd;
        @(negedge clk);
        acc_we = 1'b0; acc_re = 1'b0;
        check(acc_err == v.xerr, int'(v.req), 16'(acc_err), 16'(v.xerr), "err");
        if (v.chk)
            check(acc_rdata == v.xrd, int'(v.req), acc_rdata, v.xrd, "rdata");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        check(acc_rdata == 16'h0, 1, acc_rdata, 16'h0, "reset rdata");
        check(acc_err == 1'b0, 1, 16'(acc_err), 16'h0, "reset err");

        for (int i = 0; i < NV; i++)
            apply(TBL[i]);

        // R1 / R7: reset mid-run restores values and relocks
        apply(wr(2, 0, 64'h0013, 1'b0, 7));
        apply(wr(9, 0, 64'h00C5, 1'b0, 7));
        apply(rd(9, 16'h00C5, 1'b0, 7));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(acc_rdata == 16'h0, 1, acc_rdata, 16'h0, "rdata in reset");
        rst_n = 1'b1;
        @(negedge clk);
        apply(rd(9, 16'h0000, 1'b0, 1));
        apply(rd(2, 16'h0000, 1'b0, 1));
        apply(wr(9, 0, 64'h0001, 1'b1, 7));   // R7 locked after reset
        apply(idle(16'h0000, 11));

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule